// File: doc/BRIEF.md
# Addressed Serial Word Loader

The block takes in a 31-bit word one bit at a time on a slow serial clock and stores it in one of two banks of held registers. A rising edge on a latch line decides which bank is written, and the top bit of the word selects it. With that bit clear, the word sets three 10-bit brightness values. With it set, the word sets three 7-bit current scale values and a 2-bit clock divider code. The block presents the held values as parallel outputs, which other logic reads to drive a pulse-width output stage.

Devices can be chained. Each device passes its oldest shift bit on to the next one, and it updates that output on the falling serial clock edge, while inputs are taken on the rising edge. This keeps a chain of devices free of races. A host therefore sends the word for the farthest device first. One latch pulse then makes every device in the chain capture its own word.

The serial clock, serial data and latch lines are sampled with a fast system clock, so they may be asynchronous to it. An undervoltage flag stops all activity while it is high. When the flag falls, the shift register, the forwarded bit and both banks are cleared.

Top module: `serial_word_loader`

## Requirements
- R1: After reset all brightness, scale and divider outputs and the serial output are zero.
- R2: Each rising serial clock edge shifts the register one place toward bit 30 and loads the serial input into bit 0. The first of 31 bits sent therefore ends up in bit 30, and nothing changes between rising edges.
- R3: The serial output takes the value of bit 30 on each falling serial clock edge and holds it across rising edges.
- R4: On a latch rising edge with bit 30 equal to 0, channel k brightness (k = 0..2) takes word bits [10k+9 : 10k].
- R5: On a latch rising edge with bit 30 equal to 1, scale k takes word bits [10k+6 : 10k] and the divider takes bits [8:7]. Bits 9, 17..19 and 27..29 have no effect on any output.
- R6: A capture writes only the bank that bit 30 selects, and the other bank keeps its values.
- R7: When a latch rising edge and a serial clock rising edge are seen in the same sampling cycle, the word captured is the one that stood before that shift.
- R8: While the undervoltage flag is high the register does not shift, the serial output does not change and latch edges are ignored.
- R9: When the undervoltage flag falls, the shift register, the serial output and both banks are cleared to zero.
- R10: In a chain of two devices, a 62-bit stream leaves its first 31 bits in the far device and its last 31 bits in the near device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_i | input | 1 | Undervoltage flag, synchronous to clk, high while the supply is low |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, asynchronous |
| lat_i | input | 1 | Latch strobe, captures on its rising edge |
| sdo_o | output | 1 | Forwarded bit 30, updated on the falling serial clock edge |
| brt_o | output | 30 | Brightness values, channel k at bits [10k+9:10k] |
| scl_o | output | 21 | Current scale values, channel k at bits [7k+6:7k] |
| div_o | output | 2 | Clock divider code |

## Verification
The hardest situation to reach from the ports is a latch edge that lands in the same sampling cycle as a shift. The bench creates it by raising the latch and the serial clock in the same system clock cycle on the final bit of a chained stream. It then compares the captured banks with a bench-side model of the chain as it stood before that shift. The undervoltage freeze is also hard to see, because recovery clears the state that was frozen. The bench therefore watches the forwarded bit while it clocks data in under the flag, and it fires a latch edge under the flag before it releases it.

// File: rtl/sload_pkg.sv
// Shared constants and types for the addressed serial word loader.
// Field positions follow the word layout that the banks decode.
package sload_pkg;
    localparam int WORD_W      = 31;
    localparam int N_CH        = 3;
    localparam int BRT_W       = 10;
    localparam int SCL_W       = 7;
    localparam int DIV_W       = 2;
    localparam int LANE_STRIDE = 10;
    localparam int DIV_LSB     = 7;
    localparam int ADDR_BIT    = WORD_W - 1;

    typedef enum logic {
        BANK_BRIGHT = 1'b0,
        BANK_CONFIG = 1'b1
    } bank_e;
endpackage

// File: rtl/sload_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous level inputs.
// Assumes the bits are independent levels. Every bit sees the same
// delay, so edges that arrive together leave together.
module sload_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            // later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sload_shifter.sv
// Serial shift register with a forwarding output flop.
// Shifts on a detected rising serial edge and forwards the MSB on a
// detected falling edge. Assumes synchronized inputs that share one delay.
// hold_i freezes all state. clr_i clears it.
module sload_shifter #(
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              hold_i,
    input  logic              clr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo_o
);
    logic              sclk_q;
    logic              sh_rise;
    logic              sh_fall;
    logic [WORD_W-1:0] sh_q;
    logic              sdo_q;

    // previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sh_rise = sclk_s & ~sclk_q;
    assign sh_fall = ~sclk_s & sclk_q;

    // shift register, MSB-first input into bit 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)        sh_q <= '0;
        else if (!hold_i && sh_rise) sh_q <= {sh_q[WORD_W-2:0], sdi_s};
    end

    // forwarded bit, updated on the opposite edge for race-free chains
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)        sdo_q <= 1'b0;
        else if (!hold_i && sh_fall) sdo_q <= sh_q[WORD_W-1];
    end

    assign word_o = sh_q;
    assign sdo_o  = sdo_q;

    // R2: no shift edge means no register change
    p_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_rise && !clr_i) |=> $stable(sh_q));

    // R3: forwarded bit changes only on a falling edge
    p_sdo_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_fall && !clr_i) |=> $stable(sdo_q));

    // R8: frozen during undervoltage
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ($stable(sh_q) && $stable(sdo_q)));

    // R9: recovery clears the register and the forwarded bit
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((sh_q == '0) && !sdo_q));
endmodule

// File: rtl/sload_banks.sv
// Held register banks, written from the shift word on a latch rising edge.
// Bit ADDR_BIT selects the brightness bank or the configuration bank.
// Assumes lat_s is synchronized with the same delay as the serial clock,
// so word_i read at the capture cycle is the pre-shift word.
module sload_banks
    import sload_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_N_CH   = N_CH,
    parameter int P_BRT_W  = BRT_W,
    parameter int P_SCL_W  = SCL_W,
    parameter int P_DIV_W  = DIV_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lat_s,
    input  logic                        hold_i,
    input  logic                        clr_i,
    input  logic [P_WORD_W-1:0]         word_i,
    output logic [P_N_CH*P_BRT_W-1:0]   brt_o,
    output logic [P_N_CH*P_SCL_W-1:0]   scl_o,
    output logic [P_DIV_W-1:0]          div_o
);
    localparam int ADDR = P_WORD_W - 1;

    logic               lat_q;
    logic               cap;
    bank_e              sel;
    logic [P_BRT_W-1:0] brt_q [P_N_CH];
    logic [P_SCL_W-1:0] scl_q [P_N_CH];
    logic [P_DIV_W-1:0] div_q;

    // previous latch level for rising edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= 1'b0;
        else        lat_q <= lat_s;
    end

    assign cap = lat_s & ~lat_q & ~hold_i;
    assign sel = bank_e'(word_i[ADDR]);

    for (genvar k = 0; k < P_N_CH; k++) begin : g_ch
        // brightness lane k
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
                brt_q[k] <= '0;
            else if (cap && sel == BANK_BRIGHT)
                brt_q[k] <= word_i[k*LANE_STRIDE +: P_BRT_W];
        end

        // current scale lane k
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
                scl_q[k] <= '0;
            else if (cap && sel == BANK_CONFIG)
                scl_q[k] <= word_i[k*LANE_STRIDE +: P_SCL_W];
        end

        assign brt_o[k*P_BRT_W +: P_BRT_W] = brt_q[k];
        assign scl_o[k*P_SCL_W +: P_SCL_W] = scl_q[k];
    end

    // clock divider code, part of the configuration bank
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            div_q <= '0;
        else if (cap && sel == BANK_CONFIG)
            div_q <= word_i[DIV_LSB +: P_DIV_W];
    end

    assign div_o = div_q;

    // R6: configuration capture leaves brightness untouched
    p_keep_brt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(cap && !word_i[ADDR])) |=> $stable(brt_o));

    // R6: brightness capture leaves configuration untouched
    p_keep_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(cap && word_i[ADDR])) |=> ($stable(scl_o) && $stable(div_o)));

    // R8: no capture while held
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ($stable(brt_o) && $stable(scl_o) && $stable(div_o)));

    // R9: recovery clears both banks
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((brt_o == '0) && (scl_o == '0) && (div_o == '0)));
endmodule

// File: rtl/serial_word_loader.sv
// Top of the addressed serial word loader.
// Synchronizes the serial clock, data and latch together, shifts the word
// in, forwards the MSB downstream and captures into the bank that bit 30
// selects. uv_i is synchronous to clk. Its falling edge clears all state.
module serial_word_loader
    import sload_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  uv_i,
    input  logic                  sclk_i,
    input  logic                  sdi_i,
    input  logic                  lat_i,
    output logic                  sdo_o,
    output logic [N_CH*BRT_W-1:0] brt_o,
    output logic [N_CH*SCL_W-1:0] scl_o,
    output logic [DIV_W-1:0]      div_o
);
    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw;
    logic [N_SYNC-1:0] syn;
    logic              uv_q;
    logic              uv_clr;
    logic [WORD_W-1:0] word;

    assign raw = {lat_i, sdi_i, sclk_i};

    sload_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    // previous undervoltage level, to find recovery
    always_ff @(posedge clk) begin
        if (!rst_n) uv_q <= 1'b0;
        else        uv_q <= uv_i;
    end

    assign uv_clr = uv_q & ~uv_i;

    sload_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (syn[0]),
        .sdi_s  (syn[1]),
        .hold_i (uv_i),
        .clr_i  (uv_clr),
        .word_o (word),
        .sdo_o  (sdo_o)
    );

    sload_banks u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .lat_s  (syn[2]),
        .hold_i (uv_i),
        .clr_i  (uv_clr),
        .word_i (word),
        .brt_o  (brt_o),
        .scl_o  (scl_o),
        .div_o  (div_o)
    );

    // R1: outputs are zero in the first cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> ((brt_o == '0) && (scl_o == '0) && (div_o == '0) && !sdo_o));
endmodule

// File: tb/test_serial_word_loader.sv
`timescale 1ns/1ps
module test_serial_word_loader;
    import sload_pkg::*;

    localparam int W  = WORD_W;
    localparam int BW = N_CH*BRT_W;
    localparam int SW = N_CH*SCL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic lat = 1'b0;

    logic          sdo_a, sdo_b;
    logic [BW-1:0] brt_a, brt_b;
    logic [SW-1:0] scl_a, scl_b;
    logic [DIV_W-1:0] div_a, div_b;

    // near device receives the host stream
    serial_word_loader i_serial_word_loader (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .sclk_i(sclk), .sdi_i(sdi),
        .lat_i(lat), .sdo_o(sdo_a), .brt_o(brt_a), .scl_o(scl_a), .div_o(div_a)
    );

    // far device fed by the near device's forwarded bit
    serial_word_loader i_serial_word_loader_b (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .sclk_i(sclk), .sdi_i(sdo_a),
        .lat_i(lat), .sdo_o(sdo_b), .brt_o(brt_b), .scl_o(scl_b), .div_o(div_b)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    string sdo_tag = "R3";

    logic [2*W-1:0] chain_m;
    logic [BW-1:0]  eb_a, eb_b;
    logic [SW-1:0]  es_a, es_b;
    logic [DIV_W-1:0] ed_a, ed_b;
    logic [W-1:0]   wf, wn;

    function automatic logic [BW-1:0] pick_brt(input logic [W-1:0] w, input logic [BW-1:0] old);
        logic [BW-1:0] r = old;
        if (w[W-1] == 1'b0)
            for (int k = 0; k < N_CH; k++) r[k*BRT_W +: BRT_W] = w[k*LANE_STRIDE +: BRT_W];
        return r;
    endfunction

    function automatic logic [SW-1:0] pick_scl(input logic [W-1:0] w, input logic [SW-1:0] old);
        logic [SW-1:0] r = old;
        if (w[W-1] == 1'b1)
            for (int k = 0; k < N_CH; k++) r[k*SCL_W +: SCL_W] = w[k*LANE_STRIDE +: SCL_W];
        return r;
    endfunction

    function automatic logic [DIV_W-1:0] pick_div(input logic [W-1:0] w, input logic [DIV_W-1:0] old);
        return w[W-1] ? w[DIV_LSB +: DIV_W] : old;
    endfunction

    task automatic capture_model();
        eb_a = pick_brt(chain_m[W-1:0], eb_a);
        es_a = pick_scl(chain_m[W-1:0], es_a);
        ed_a = pick_div(chain_m[W-1:0], ed_a);
        eb_b = pick_brt(chain_m[2*W-1:W], eb_b);
        es_b = pick_scl(chain_m[2*W-1:W], es_b);
        ed_b = pick_div(chain_m[2*W-1:W], ed_b);
    endtask

    task automatic clear_model();
        chain_m = '0;
        eb_a = '0; eb_b = '0; es_a = '0; es_b = '0; ed_a = '0; ed_b = '0;
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_banks(input string tag);
        chk(tag, "near brightness", 64'(brt_a), 64'(eb_a));
        chk(tag, "near scales",     64'(scl_a), 64'(es_a));
        chk(tag, "near divider",    64'(div_a), 64'(ed_a));
        chk(tag, "far brightness",  64'(brt_b), 64'(eb_b));
        chk(tag, "far scales",      64'(scl_b), 64'(es_b));
        chk(tag, "far divider",     64'(div_b), 64'(ed_b));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit; optional latch raised together with the rising edge
    task automatic send_bit(input logic b, input logic with_lat);
        logic pa, pb;
        sdi = b;
        tick(3);
        pa = chain_m[W-1];
        pb = chain_m[2*W-1];
        if (!uv) begin
            if (with_lat) capture_model();
            chain_m = {chain_m[2*W-2:0], b};
        end
        sclk = 1'b1;
        if (with_lat) lat = 1'b1;
        tick(6);
        chk(sdo_tag, "near sdo after rise", 64'(sdo_a), 64'(pa));
        chk(sdo_tag, "far sdo after rise",  64'(sdo_b), 64'(pb));
        sclk = 1'b0;
        tick(6);
        chk(sdo_tag, "near sdo after fall", 64'(sdo_a), 64'(chain_m[W-1]));
        chk(sdo_tag, "far sdo after fall",  64'(sdo_b), 64'(chain_m[2*W-1]));
        if (with_lat) begin
            lat = 1'b0;
            tick(2);
        end
    endtask

    // far word goes first so that it travels through the near device
    task automatic send_pair(input logic [W-1:0] far_w, input logic [W-1:0] near_w);
        for (int i = W-1; i >= 0; i--) send_bit(far_w[i], 1'b0);
        for (int i = W-1; i >= 0; i--) send_bit(near_w[i], 1'b0);
    endtask

    task automatic latch_pulse();
        tick(2);
        if (!uv) capture_model();
        lat = 1'b1;
        tick(6);
        lat = 1'b0;
        tick(6);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(5.0 * 180000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        clear_model();
        tick(4);
        // R1: state held in reset
        check_banks("R1");
        chk("R1", "near sdo", 64'(sdo_a), 64'd0);
        chk("R1", "far sdo",  64'(sdo_b), 64'd0);
        rst_n = 1'b1;
        tick(4);
        check_banks("R1");

        // R2 R4 R10: brightness sweep through the chain
        for (int i = 0; i < 12; i++) begin
            wf = '0;
            wn = '0;
            for (int k = 0; k < N_CH; k++) begin
                int vf, vn;
                vf = (i*389 + k*211 + 7) % 1024;
                vn = (i*157 + k*601 + 3) % 1024;
                if (i == 0) begin vf = 0;    vn = 1023; end
                if (i == 1) begin vf = 1023; vn = 0;    end
                wf[k*LANE_STRIDE +: BRT_W] = BRT_W'(vf);
                wn[k*LANE_STRIDE +: BRT_W] = BRT_W'(vn);
            end
            send_pair(wf, wn);
            latch_pulse();
            check_banks("R2 R4 R10");
        end

        // R5 R6: configuration sweep, all divider codes, unused bits toggled
        for (int j = 0; j < 8; j++) begin
            logic [2:0] jb;
            jb = 3'(j);
            wf = '0;
            wn = '0;
            wf[W-1] = 1'b1;
            wn[W-1] = 1'b1;
            for (int k = 0; k < N_CH; k++) begin
                int sf, sn;
                sf = (j*37 + k*53 + 5) % 128;
                sn = (j*71 + k*29 + 11) % 128;
                if (j == 7) begin sf = 127; sn = 0; end
                wf[k*LANE_STRIDE +: SCL_W] = SCL_W'(sf);
                wn[k*LANE_STRIDE +: SCL_W] = SCL_W'(sn);
            end
            wf[DIV_LSB +: DIV_W] = DIV_W'(j % 4);
            wn[DIV_LSB +: DIV_W] = DIV_W'(3 - (j % 4));
            wf[9] = jb[0];
            wf[17 +: 3] = jb ^ 3'b101;
            wf[27 +: 3] = ~jb;
            wn[9] = ~jb[1];
            wn[17 +: 3] = ~jb;
            wn[27 +: 3] = jb;
            send_pair(wf, wn);
            latch_pulse();
            check_banks("R5 R6");
        end

        // R6: brightness load keeps the configuration bank
        wf = {1'b0, 10'd5, 10'd600, 10'd1023};
        wn = {1'b0, 10'd900, 10'd0, 10'd77};
        send_pair(wf, wn);
        latch_pulse();
        check_banks("R6");

        // R7: latch edge together with the last shift edge
        wf = {1'b1, 3'b000, 3'b000, 7'd99, 3'b000, 7'd42, 1'b0, 2'd2, 7'd17};
        wn = {1'b0, 10'd300, 10'd511, 10'd1};
        for (int i = W-1; i >= 0; i--) send_bit(wf[i], 1'b0);
        for (int i = W-1; i >= 1; i--) send_bit(wn[i], 1'b0);
        send_bit(wn[0], 1'b1);
        tick(4);
        check_banks("R7");

        // R8: undervoltage freeze, with a word pending in the register
        wf = {1'b1, 30'h2AAA_5555};
        wn = {1'b1, 30'h1234_5678};
        send_pair(wf, wn);
        uv = 1'b1;
        tick(3);
        sdo_tag = "R8";
        for (int i = 0; i < W; i++) send_bit(1'(i % 2), 1'b0);
        latch_pulse();
        check_banks("R8");

        // R9: recovery clears everything
        uv = 1'b0;
        clear_model();
        tick(4);
        check_banks("R9");
        chk("R9", "near sdo", 64'(sdo_a), 64'd0);
        chk("R9", "far sdo",  64'(sdo_b), 64'd0);
        sdo_tag = "R3";

        // R2 R9: operation resumes after recovery
        wf = {1'b0, 10'd700, 10'd11, 10'd222};
        wn = {1'b1, 3'b111, 3'b000, 7'd127, 3'b111, 7'd64, 1'b1, 2'd1, 7'd3};
        send_pair(wf, wn);
        latch_pulse();
        check_banks("R2 R9");

        summary();
        $finish;
    end
endmodule